// File: doc/BRIEF.md
# Nonvolatile Array Write Guard with Region Locking

This block stands in front of a 4096-byte nonvolatile array and decides, one request at a time, whether a write may go ahead. A protection register lives at the very top of the 16-bit address space. It holds three controls:

- a write-enable latch;
- a two-bit selector that locks nothing, the upper quarter, the upper half or the whole array;
- a freeze bit that, together with a hardware protect pin, makes the locked regions and the register itself unchangeable.

Each request carries an address, up to 32 data bytes, a page flag and a byte count. One cycle later the block answers with a grant or a reject pulse. Granted array bytes land in a plain RAM model that can be read combinationally.

A granted nonvolatile change starts a self-timed write period. The period is modelled by a cycle counter, and every request that arrives while the counter runs is refused. Changes to the write-enable latch alone are volatile and do not start that period. A request aimed at the unused hole between the array and the register is refused and also raises a separate range flag.

Top module: `eeprom_lock_guard`

## Requirements
- R1: After reset the protection register reads 00h, `busy` is low, and `grant`, `reject` and `range_err` are low.
- R2: The protection register holds the write-enable latch in bit 1, the lock selector in bits 4:3 and the freeze bit in bit 7. All other bits always read 0.
- R3: While the write-enable latch is 0, every array write is rejected. While the latch is 0, a register write is granted, sets the latch to data bit 1, leaves every other bit unchanged and does not start a write period.
- R4: The lock selector protects array addresses as follows: 00 protects none, 01 protects C00h–FFFh, 10 protects 800h–FFFh and 11 protects 000h–FFFh. A write touching a protected byte is rejected.
- R5: When the freeze bit is 1 and `wp_pin` is high, every register write is rejected. Array writes outside the locked range are still granted when the latch is 1.
- R6: When the register is not frozen and the latch is 1, a register write with data bit 1 set is granted even if array regions are locked. It stores data bits 7, 4 and 3, keeps the latch at 1 and starts a write period. The same write with data bit 1 clear is granted, clears only the latch and starts no write period.
- R7: A page write (`req_page` = 1) covers `req_last`+1 bytes. The bytes start at the request address and wrap inside its 32-byte aligned page. Byte i comes from `req_data[8i+7:8i]`. The page is granted only if no covered byte is locked; otherwise nothing is written. With `req_page` = 0 exactly one byte (byte 0) is written.
- R8: A granted array write or register update makes `busy` high for exactly WR_CYCLES cycles after the accepting edge. Every request sampled while `busy` is high is rejected.
- R9: A request to any address from 1000h to FFFEh is rejected, and `range_err` pulses with `reject`. This also holds while `busy` is high.
- R10: The response is registered. For a request sampled at an edge, exactly one of `grant` and `reject` is high for the following cycle. Both are low after a cycle with no request.
- R11: A rejected request changes neither the array contents nor the protection register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present this cycle |
| req_addr | input | 16 | Target address (FFFFh is the protection register) |
| req_page | input | 1 | Request is a page write |
| req_last | input | 5 | Byte count minus one for a page write |
| req_data | input | 256 | Data bytes, byte i in bits 8i+7:8i |
| wp_pin | input | 1 | Hardware protect pin level |
| rd_addr | input | 12 | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |
| prot_reg | output | 8 | Current protection register value |
| busy | output | 1 | Self-timed write period running |
| grant | output | 1 | Previous request accepted |
| reject | output | 1 | Previous request refused |
| range_err | output | 1 | Previous request hit the unused address hole |

## Verification
The two functions that can meet in one cycle are the end of a write period and the arrival of a new request. The bench issues a request on every cycle of a busy period and on the cycles just after it. The last request that still sees the counter at one must be refused, and the very next request must be judged on its protection rules alone. A second overlap is a range error arriving during a busy period: both reasons for refusal apply, and the flag must still pulse. The behavioural model in the bench tracks the counter as a plain integer and the array as a byte table. Every clock it compares the response pulses, `busy`, the register value and a probed array byte against that model.

// File: rtl/eeprom_lock_guard.sv
module eeprom_lock_guard #(
  parameter int ADDR_W     = 16,
  parameter int ARR_W      = 12,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 50
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_page,
  input  logic [$clog2(PAGE_BYTES)-1:0] req_last,
  input  logic [PAGE_BYTES*8-1:0] req_data,
  input  logic                    wp_pin,
  input  logic [ARR_W-1:0]        rd_addr,
  output logic [7:0]              rd_data,
  output logic [7:0]              prot_reg,
  output logic                    busy,
  output logic                    grant,
  output logic                    reject,
  output logic                    range_err
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int DEPTH = 1 << ARR_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [7:0] KEEP_MASK = 8'h98;

  logic [7:0]       mem [DEPTH];
  logic [7:0]       preg;
  logic [CNT_W-1:0] cnt;

  logic       wel, wpen, frozen;
  logic [1:0] lock_sel;
  logic       is_reg, in_arr, out_rng;
  logic [OFF_W:0] n_bytes;
  logic       page_hit;
  logic       arr_ok, reg_latch, reg_nv, accept, arr_go, nv_start;

  assign wel      = preg[1];
  assign lock_sel = preg[4:3];
  assign wpen     = preg[7];
  assign frozen   = wpen & wp_pin;

  assign is_reg  = &req_addr;
  assign in_arr  = req_addr[ADDR_W-1:ARR_W] == '0;
  assign out_rng = !is_reg && !in_arr;
  assign busy    = cnt != '0;

  assign n_bytes = req_page ? ({1'b0, req_last} + 1'b1) : (OFF_W+1)'(1);

  function automatic logic is_locked(input logic [ARR_W-1:0] a, input logic [1:0] sel);
    case (sel)
      2'b01:   return a[ARR_W-1:ARR_W-2] == 2'b11;
      2'b10:   return a[ARR_W-1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    page_hit = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (i < int'(n_bytes)) begin
        if (is_locked({req_addr[ARR_W-1:OFF_W], req_addr[OFF_W-1:0] + OFF_W'(i)}, lock_sel))
          page_hit = 1'b1;
      end
    end
  end

  assign arr_ok    = in_arr && wel && !page_hit;
  assign reg_latch = is_reg && !frozen && (!wel || !req_data[1]);
  assign reg_nv    = is_reg && !frozen && wel && req_data[1];
  assign accept    = req_valid && !busy && (arr_ok || reg_latch || reg_nv);
  assign arr_go    = accept && arr_ok;
  assign nv_start  = accept && (arr_ok || reg_nv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preg      <= '0;
      cnt       <= '0;
      grant     <= 1'b0;
      reject    <= 1'b0;
      range_err <= 1'b0;
    end else begin
      grant     <= accept;
      reject    <= req_valid && !accept;
      range_err <= req_valid && out_rng;
      if (nv_start)
        cnt <= CNT_W'(WR_CYCLES);
      else if (busy)
        cnt <= cnt - 1'b1;
      if (accept && reg_nv)
        preg <= (req_data[7:0] & KEEP_MASK) | 8'h02;
      else if (accept && reg_latch)
        preg[1] <= req_data[1];
    end
  end

  always_ff @(posedge clk) begin
    if (arr_go) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (i < int'(n_bytes))
          mem[{req_addr[ARR_W-1:OFF_W], req_addr[OFF_W-1:0] + OFF_W'(i)}] <= req_data[i*8 +: 8];
      end
    end
  end

  assign rd_data  = mem[rd_addr];
  assign prot_reg = preg;
endmodule

// File: rtl/eeprom_lock_guard_chk.sv
module eeprom_lock_guard_chk #(
  parameter int ADDR_W = 16,
  parameter int ARR_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              wp_pin,
  input logic [7:0]        prot_reg,
  input logic              busy,
  input logic              grant,
  input logic              reject,
  input logic              range_err
);
  logic arr_target;
  assign arr_target = req_addr[ADDR_W-1:ARR_W] == '0;

  assert_one_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && reject));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !grant && !reject);

  assert_busy_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && busy |=> reject);

  assert_range_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> reject);

  assert_frozen_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (&req_addr) && prot_reg[7] && wp_pin |=> reject);

  assert_wel_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && arr_target && !prot_reg[1] |=> reject);

  assert_full_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && arr_target && prot_reg[4:3] == 2'b11 |=> reject);

  assert_reg_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_reg) |-> grant);

  assert_reserved_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_reg & 8'h65) == 8'h00);
endmodule

bind eeprom_lock_guard eeprom_lock_guard_chk #(.ADDR_W(ADDR_W), .ARR_W(ARR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .wp_pin(wp_pin), .prot_reg(prot_reg), .busy(busy), .grant(grant),
  .reject(reject), .range_err(range_err)
);

// File: tb/eeprom_lock_guard_tb_top.sv
`timescale 1ns/1ps
module eeprom_lock_guard_tb_top;
  localparam int WR = 50;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [15:0]  req_addr = '0;
  logic         req_page = 1'b0;
  logic [4:0]   req_last = '0;
  logic [255:0] req_data = '0;
  logic         wp_pin = 1'b0;
  logic [11:0]  rd_addr = '0;
  logic [7:0]   rd_data, prot_reg;
  logic         busy, grant, reject, range_err;

  eeprom_lock_guard #(.WR_CYCLES(WR)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_page(req_page), .req_last(req_last), .req_data(req_data), .wp_pin(wp_pin),
    .rd_addr(rd_addr), .rd_data(rd_data), .prot_reg(prot_reg), .busy(busy),
    .grant(grant), .reject(reject), .range_err(range_err));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_reg = 0, m_cnt = 0;
  byte unsigned m_mem [4096];
  bit m_known [4096];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit lk(input int a, input int sel);
    case (sel)
      1: return a >= 'hC00;
      2: return a >= 'h800;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic cyc(input bit v, input int addr, input bit pg, input int last, input string tag);
    bit eg, er, ern, hit;
    int n, base, off, a;
    bit was_busy;
    eg = 0; er = 0; ern = 0; hit = 0;
    req_valid = v; req_addr = addr[15:0]; req_page = pg; req_last = last[4:0];
    was_busy = m_cnt > 0;
    if (v) begin
      ern = (addr >= 'h1000) && (addr <= 'hFFFE);
      if (was_busy || ern) er = 1;
      else if (addr == 'hFFFF) begin
        if (m_reg[7] && wp_pin) er = 1;
        else if (!m_reg[1] || !req_data[1]) begin
          eg = 1; m_reg[1] = req_data[1];
        end else begin
          eg = 1; m_reg = (int'(req_data[7:0]) & 'h98) | 'h02; m_cnt = WR + 1;
        end
      end else if (!m_reg[1]) er = 1;
      else begin
        n = pg ? last + 1 : 1;
        base = addr - addr % 32; off = addr % 32;
        for (int i = 0; i < n; i++) if (lk(base + (off + i) % 32, (m_reg >> 3) & 3)) hit = 1;
        if (hit) er = 1;
        else begin
          eg = 1; m_cnt = WR + 1;
          for (int i = 0; i < n; i++) begin
            a = base + (off + i) % 32;
            m_mem[a] = req_data[i*8 +: 8]; m_known[a] = 1;
          end
        end
      end
    end
    if (m_cnt > 0) m_cnt--;
    @(posedge clk); @(negedge clk);
    chk(grant == eg, tag, "grant", grant, eg);
    chk(reject == er, tag, "reject", reject, er);
    chk(range_err == ern, tag, "range_err", range_err, ern);
    chk(busy == (m_cnt > 0), tag, "busy", busy, m_cnt > 0);
    chk(prot_reg == m_reg[7:0], tag, "prot_reg", prot_reg, m_reg);
    if (m_known[rd_addr]) chk(rd_data == m_mem[rd_addr], tag, "rd_data", rd_data, m_mem[rd_addr]);
    req_valid = 0;
  endtask

  task automatic drain(input string tag);
    while (m_cnt > 0) cyc(0, 0, 0, 0, tag);
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 32; i++) req_data[i*8 +: 8] = 8'(seed + i * 7);
  endtask

  task automatic wr1(input int addr, input int d, input string tag);
    req_data[7:0] = d[7:0];
    cyc(1, addr, 0, 0, tag);
  endtask

  task automatic finish_up;
    if (done) return;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(prot_reg == 0 && !busy && !grant && !reject && !range_err, "R1", "reset state",
        {prot_reg, busy, grant, reject, range_err}, 0);
    rst_n = 1;
    cyc(0, 0, 0, 0, "R1");

    rd_addr = 12'h010;
    wr1('h010, 'hA5, "R3");
    wr1('hFFFF, 'hFF, "R3");
    wr1('hFFFF, 'h00, "R6");
    wr1('hFFFF, 'h02, "R3");
    wr1('h010, 'hA5, "R7");
    for (int i = 0; i < WR + 3; i++) begin
      req_data[7:0] = 8'(i);
      cyc(1, 'h011, 0, 0, "R8");
    end
    rd_addr = 12'h011;
    drain("R8");
    wr1('h1234, 0, "R9");
    wr1('hFFFE, 0, "R9");
    wr1('h0020, 'h3C, "R8");
    wr1('hF000, 0, "R9");
    drain("R8");

    wr1('hFFFF, 'h6A, "R2");
    drain("R2");
    rd_addr = 12'hC00;
    wr1('hC00, 'h11, "R4");
    wr1('hFFF, 'h11, "R4");
    rd_addr = 12'hBFF;
    wr1('hBFF, 'h22, "R4");
    drain("R4");

    rd_addr = 12'hBE0;
    fill(3);
    cyc(1, 'hBFC, 1, 7, "R7");
    drain("R7");
    rd_addr = 12'hBFC;
    cyc(0, 0, 0, 0, "R7");
    fill(9);
    rd_addr = 12'hBE5;
    cyc(1, 'hBE5, 0, 20, "R7");
    drain("R7");
    rd_addr = 12'hBE6;
    cyc(0, 0, 0, 0, "R7");
    rd_addr = 12'hFE0;
    fill(40);
    cyc(1, 'hFE0, 1, 31, "R11");

    wr1('hFFFF, 'h12, "R6");
    drain("R6");
    wr1('h900, 'h33, "R4");
    rd_addr = 12'h7FF;
    wr1('h7FF, 'h44, "R4");
    drain("R4");
    wr1('hFFFF, 'h1A, "R6");
    drain("R6");
    rd_addr = 12'h000;
    wr1('h000, 'h55, "R4");
    fill(77);
    cyc(1, 'h400, 1, 31, "R4");

    wr1('hFFFF, 'h8A, "R6");
    drain("R6");
    wp_pin = 1;
    wr1('hFFFF, 'h00, "R5");
    wr1('hFFFF, 'h9A, "R5");
    rd_addr = 12'h123;
    wr1('h123, 'h66, "R5");
    drain("R5");
    wr1('hD00, 'h66, "R11");
    wp_pin = 0;
    wr1('hFFFF, 'h00, "R6");
    wr1('h124, 'h77, "R3");
    wr1('hFFFF, 'h02, "R3");
    wr1('hFFFF, 'h02, "R6");
    drain("R6");
    wr1('hD00, 'h88, "R4");
    finish_up();
  end
endmodule